// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects a parameterized set of level-sensitive interrupt lines, 64 by default, and presents them to a small number of CPUs. Each line has a mask bit and a software-pending bit. The software-pending bit is ORed with the hardware level. Each line also has a steering register that selects which CPUs may see it. A CPU learns which line to service by reading a single event register. That read returns the lowest-numbered line that is pending, unmasked and steered to that CPU. The same read also masks the line, so a level that stays high cannot fire again. Software unmasks the line through the mask-clear bank once the source has been serviced.

The register side has two plain channels. A read channel carries an address and the index of the requesting CPU, and returns the data one cycle after the strobe. A write channel carries an address and a data word. Both channels may be active in the same cycle. Each CPU also has one interrupt output, which is high whenever an event read by that CPU would return a non-zero word. The register port is a plain strobe interface, not a stream: it never stalls, so there is no back-pressure. A read strobe always produces data on the next cycle, and a write strobe always takes effect at the clock edge that samples it.

Register offsets (byte addresses): line count at 0x0000, CPU index at 0x0008, event at 0x000C, mask-set bank at 0x0100, mask-clear bank at 0x0180, software-set bank at 0x0200, software-clear bank at 0x0280, and steering registers at 0x1000 + 4 x line.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every software-pending bit is 0, every steering register reads 1 (CPU 0 only), and every interrupt output is low even with all hardware lines high.
- R2: A line is pending when (hardware level OR software bit) AND NOT mask. Interrupt output c is high exactly when some pending line has bit c set in its steering register.
- R3: The event word is {16'd1, 16-bit line number} when a line is reported, and all zeros when nothing is pending for the reading CPU. Read data appears on rd_data in the cycle after rd_en.
- R4: Among the lines pending for the reading CPU, the lowest-numbered one is reported.
- R5: An event read that reports a line sets that line's mask bit. An event read that returns zero changes no state.
- R6: Writing to the mask-set or mask-clear bank at word w sets or clears the mask of line 32w+b for each 1 bit b of the data. Data bits that are 0 leave the mask unchanged. Reading either bank returns the current mask word.
- R7: The software-set and software-clear banks use the same word and bit layout as the mask banks and drive the software-pending bits. Reading either bank returns the software word.
- R8: The steering register of line n holds one bit per CPU. A line is offered to every CPU whose bit is set, and to none when the register is zero.
- R9: The line-count register returns the number of lines in bits 15:0. The CPU-index register returns rd_cpu.
- R10: When an event read and a mask-clear write of the reported line occur in the same cycle, the line ends up masked.
- R11: A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | N_LINES | Hardware interrupt levels |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_cpu | input | CPU_W | Index of the CPU issuing the read |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| irq_o | output | N_CPUS | Per-CPU interrupt request |

## Verification
The assertions assume that rd_cpu always names an existing CPU and that the hardware levels change only between clock edges. Under those conditions, a reported line can be traced back to the eligible set of the previous cycle. The stimulus draws the CPU index only from the implemented range and drives every input at the falling edge. Steering values are random, so they include zero and multi-bit patterns. The hardware pattern is also random, so many lines compete at once and the priority order and auto-mask are exercised together.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned OFF_INFO   = 32'h0000;
  localparam int unsigned OFF_WHO    = 32'h0008;
  localparam int unsigned OFF_EVT    = 32'h000C;
  localparam int unsigned OFF_MSET   = 32'h0100;
  localparam int unsigned OFF_MCLR   = 32'h0180;
  localparam int unsigned OFF_SSET   = 32'h0200;
  localparam int unsigned OFF_SCLR   = 32'h0280;
  localparam int unsigned OFF_TGT    = 32'h1000;
  localparam logic [15:0] EVT_KIND_HW = 16'd1;
endpackage

// File: rtl/ipc_line_bank.sv
module ipc_line_bank #(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_LINES-1:0]              mset,
  input  logic [N_LINES-1:0]              mclr,
  input  logic [N_LINES-1:0]              sset,
  input  logic [N_LINES-1:0]              sclr,
  input  logic [N_LINES-1:0]              ack,
  input  logic [N_LINES-1:0]              tgt_we,
  input  logic [N_CPUS-1:0]               tgt_wdata,
  output logic [N_LINES-1:0]              mask_q,
  output logic [N_LINES-1:0]              sw_q,
  output logic [N_LINES-1:0][N_CPUS-1:0]  tgt_q
);
  localparam logic [N_CPUS-1:0] TGT_RST = N_CPUS'(1);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[i] <= 1'b1;
        sw_q[i]   <= 1'b0;
        tgt_q[i]  <= TGT_RST;
      end else begin
        // auto-mask from an event read overrides a same-cycle clear
        mask_q[i] <= ((mask_q[i] | mset[i]) & ~mclr[i]) | ack[i];
        sw_q[i]   <= (sw_q[i] | sset[i]) & ~sclr[i];
        if (tgt_we[i]) tgt_q[i] <= tgt_wdata;
      end
    end
  end
endmodule

// File: rtl/ipc_pick.sv
module ipc_pick #(
  parameter int N_LINES = 64,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] cand,
  output logic               any,
  output logic [IW-1:0]      idx
);
  always_comb begin
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
    any = |cand;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 4,
  parameter int ADDR_W  = 16,
  localparam int CPU_W  = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] hw_irq,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [CPU_W-1:0]   rd_cpu,
  output logic [31:0]        rd_data,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  output logic [N_CPUS-1:0]  irq_o
);
  localparam int IW = $clog2(N_LINES);
  localparam int NW = (N_LINES + 31) / 32;

  logic [N_LINES-1:0]             mask_q, sw_q, pend_v, ack_vec, tgt_we;
  logic [N_LINES-1:0][N_CPUS-1:0] tgt_q;
  logic [NW*32-1:0]               mset_p, mclr_p, sset_p, sclr_p, mask_p, sw_p;
  logic [N_CPUS*N_LINES-1:0]      elig_flat;
  logic [N_CPUS-1:0]              pick_any;
  logic [N_CPUS-1:0][IW-1:0]      pick_idx;
  logic                           sel_any, evt_rd;
  logic [IW-1:0]                  sel_idx;
  logic [31:0]                    evt_word, rd_next, rd_q;

  // write decode of the bit banks and steering registers
  always_comb begin
    mset_p = '0; mclr_p = '0; sset_p = '0; sclr_p = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_en && wr_addr == ADDR_W'(OFF_MSET + 4*w)) mset_p[w*32 +: 32] = wr_data;
      if (wr_en && wr_addr == ADDR_W'(OFF_MCLR + 4*w)) mclr_p[w*32 +: 32] = wr_data;
      if (wr_en && wr_addr == ADDR_W'(OFF_SSET + 4*w)) sset_p[w*32 +: 32] = wr_data;
      if (wr_en && wr_addr == ADDR_W'(OFF_SCLR + 4*w)) sclr_p[w*32 +: 32] = wr_data;
    end
    for (int i = 0; i < N_LINES; i++) begin
      tgt_we[i] = wr_en && wr_addr == ADDR_W'(OFF_TGT + 4*i);
    end
  end

  ipc_line_bank #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .mset      (mset_p[N_LINES-1:0]),
    .mclr      (mclr_p[N_LINES-1:0]),
    .sset      (sset_p[N_LINES-1:0]),
    .sclr      (sclr_p[N_LINES-1:0]),
    .ack       (ack_vec),
    .tgt_we    (tgt_we),
    .tgt_wdata (wr_data[N_CPUS-1:0]),
    .mask_q    (mask_q),
    .sw_q      (sw_q),
    .tgt_q     (tgt_q)
  );

  assign pend_v = (hw_irq | sw_q) & ~mask_q;

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    logic [N_LINES-1:0] cand;
    always_comb begin
      for (int i = 0; i < N_LINES; i++) cand[i] = pend_v[i] & tgt_q[i][c];
    end
    assign elig_flat[c*N_LINES +: N_LINES] = cand;
    ipc_pick #(.N_LINES(N_LINES)) u_pick (
      .cand (cand),
      .any  (pick_any[c]),
      .idx  (pick_idx[c])
    );
  end

  assign irq_o = pick_any;

  // select the requesting CPU's winner and form the auto-mask
  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int c = 0; c < N_CPUS; c++) begin
      if (rd_cpu == CPU_W'(c)) begin
        sel_any = pick_any[c];
        sel_idx = pick_idx[c];
      end
    end
    evt_rd  = rd_en && rd_addr == ADDR_W'(OFF_EVT);
    ack_vec = '0;
    if (evt_rd && sel_any) ack_vec[sel_idx] = 1'b1;
    evt_word = sel_any ? {EVT_KIND_HW, 16'(sel_idx)} : 32'd0;
  end

  // read mux
  always_comb begin
    mask_p = '0; mask_p[N_LINES-1:0] = mask_q;
    sw_p   = '0; sw_p[N_LINES-1:0]   = sw_q;
    rd_next = '0;
    if (rd_addr == ADDR_W'(OFF_INFO)) rd_next = 32'(N_LINES);
    if (rd_addr == ADDR_W'(OFF_WHO))  rd_next = 32'(rd_cpu);
    if (rd_addr == ADDR_W'(OFF_EVT))  rd_next = evt_word;
    for (int w = 0; w < NW; w++) begin
      if (rd_addr == ADDR_W'(OFF_MSET + 4*w) || rd_addr == ADDR_W'(OFF_MCLR + 4*w))
        rd_next = mask_p[w*32 +: 32];
      if (rd_addr == ADDR_W'(OFF_SSET + 4*w) || rd_addr == ADDR_W'(OFF_SCLR + 4*w))
        rd_next = sw_p[w*32 +: 32];
    end
    for (int i = 0; i < N_LINES; i++) begin
      if (rd_addr == ADDR_W'(OFF_TGT + 4*i)) rd_next = 32'(tgt_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk
  import ipc_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 4,
  parameter int ADDR_W  = 16,
  parameter int CPU_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          rd_addr,
  input logic [CPU_W-1:0]           rd_cpu,
  input logic [31:0]                rd_data,
  input logic [N_CPUS-1:0]          irq_o,
  input logic [N_LINES-1:0]         mask_q,
  input logic [N_CPUS*N_LINES-1:0]  elig_flat
);
  localparam int IW = $clog2(N_LINES);

  logic               ev_q;
  logic [N_LINES-1:0] prev_elig_q;
  logic [IW-1:0]      rep_idx;
  logic [N_LINES-1:0] below;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q        <= 1'b0;
      prev_elig_q <= '0;
    end else begin
      ev_q        <= rd_en && rd_addr == ADDR_W'(OFF_EVT);
      prev_elig_q <= elig_flat[rd_cpu*N_LINES +: N_LINES];
    end
  end

  assign rep_idx = rd_data[IW-1:0];
  assign below   = (N_LINES'(1) << rep_idx) - N_LINES'(1);

  AST_EVT_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && rd_data != 32'd0) |-> (rd_data[31:16] == EVT_KIND_HW && rd_data[15:0] < 16'(N_LINES))); // R3
  AST_EVT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && rd_data == 32'd0) |-> (prev_elig_q == '0)); // R3
  AST_EVT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && rd_data != 32'd0) |-> prev_elig_q[rep_idx]); // R2
  AST_EVT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && rd_data != 32'd0) |-> ((prev_elig_q & below) == '0)); // R4
  AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && rd_data != 32'd0) |-> mask_q[rep_idx]); // R10
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (irq_o == '0)); // R1
endmodule

bind irq_prio_ctrl ipc_chk #(
  .N_LINES (N_LINES),
  .N_CPUS  (N_CPUS),
  .ADDR_W  (ADDR_W),
  .CPU_W   (CPU_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_cpu    (rd_cpu),
  .rd_data   (rd_data),
  .irq_o     (irq_o),
  .mask_q    (mask_q),
  .elig_flat (elig_flat)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int N = 64;
  localparam int C = 4;
  localparam logic [15:0] A_INFO = 16'h0000, A_WHO = 16'h0008, A_EVT = 16'h000C,
                          A_MSET = 16'h0100, A_MCLR = 16'h0180, A_SSET = 16'h0200,
                          A_SCLR = 16'h0280, A_TGT = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] hw_irq = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] rd_addr = '0, wr_addr = '0;
  logic [1:0] rd_cpu = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [C-1:0] irq_o;

  int n_cmp = 0, n_bad = 0;
  logic [N-1:0] mask_m, sw_m;
  logic [C-1:0] tgt_m [N];

  always #4 clk = ~clk;

  irq_prio_ctrl #(.N_LINES(N), .N_CPUS(C), .ADDR_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_cpu(rd_cpu), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_evt(input int cpu);
    for (int i = 0; i < N; i++)
      if ((hw_irq[i] | sw_m[i]) && !mask_m[i] && tgt_m[i][cpu]) return {16'd1, 16'(i)};
    return 32'd0;
  endfunction

  function automatic logic [C-1:0] exp_irq();
    logic [C-1:0] r = '0;
    for (int c = 0; c < C; c++) r[c] = (exp_evt(c) != 32'd0);
    return r;
  endfunction

  // all tasks start and end at a falling edge
  task automatic rd(input logic [15:0] a, input int cpu, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a; rd_cpu = 2'(cpu);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    for (int b = 0; b < 32; b++) begin
      if (a >= A_MSET && a < A_MSET + 16'd8 && d[b]) mask_m[(a - A_MSET) * 8 + 16'(b)] = 1'b1;
      if (a >= A_MCLR && a < A_MCLR + 16'd8 && d[b]) mask_m[(a - A_MCLR) * 8 + 16'(b)] = 1'b0;
      if (a >= A_SSET && a < A_SSET + 16'd8 && d[b]) sw_m[(a - A_SSET) * 8 + 16'(b)] = 1'b1;
      if (a >= A_SCLR && a < A_SCLR + 16'd8 && d[b]) sw_m[(a - A_SCLR) * 8 + 16'(b)] = 1'b0;
    end
    if (a >= A_TGT && a < A_TGT + 16'(4*N)) tgt_m[(a - A_TGT) >> 2] = d[C-1:0];
  endtask

  task automatic evt(input int cpu, input string req);
    logic [31:0] e, d;
    e = exp_evt(cpu);
    rd(A_EVT, cpu, d);
    chk(req, d, e);
    if (e != 32'd0) mask_m[e[5:0]] = 1'b1;
  endtask

  task automatic chk_irq(input string req);
    chk(req, 32'(irq_o), 32'(exp_irq()));
  endtask

  logic [31:0] d;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mask_m = '1; sw_m = '0;
    for (int i = 0; i < N; i++) tgt_m[i] = 4'b0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hw_irq = '1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq low", 32'(irq_o), 32'd0);
    rd(A_MSET, 0, d); chk("R1 mask word0", d, 32'hFFFF_FFFF);
    rd(A_MCLR + 4, 0, d); chk("R1 mask word1", d, 32'hFFFF_FFFF);
    rd(A_SSET + 4, 0, d); chk("R1 sw word1", d, 32'd0);
    rd(A_TGT + 16'd20, 0, d); chk("R1 target", d, 32'd1);
    evt(0, "R1 event empty");
    // R9 identity registers
    rd(A_INFO, 1, d); chk("R9 info", d, 32'd64);
    rd(A_WHO, 2, d); chk("R9 whoami", d, 32'd2);
    // R11 unmapped
    rd(16'h0040, 0, d); chk("R11 unmapped", d, 32'd0);
    // R4/R5 priority and auto-mask
    hw_irq = '0; hw_irq[3] = 1'b1; hw_irq[40] = 1'b1;
    wr(A_MCLR + 4, 32'h100); wr(A_MCLR, 32'h8);
    chk_irq("R2 irq two lines");
    evt(0, "R4 lowest first");
    evt(0, "R5 next line");
    evt(0, "R5 empty after auto-mask");
    rd(A_MSET, 0, d); chk("R5 mask bit3 back", d, 32'hFFFF_FFFF);
    // R6 zero bits ignored
    wr(A_MCLR, 32'h0000_0010);
    wr(A_MSET, 32'h0);
    rd(A_MCLR, 0, d); chk("R6 zero write no effect", d, 32'hFFFF_FFEF);
    // R7 software trigger
    hw_irq = '0;
    wr(A_MCLR, 32'h80); wr(A_SSET, 32'h80);
    chk("R7 sw raises irq", 32'(irq_o), 32'h1);
    rd(A_SCLR, 0, d); chk("R7 sw word", d, 32'h80);
    wr(A_SCLR, 32'h80);
    chk("R7 sw cleared", 32'(irq_o), 32'h0);
    // R8 steering
    hw_irq[10] = 1'b1;
    wr(A_MCLR, 32'h400); wr(A_TGT + 16'd40, 32'h4);
    chk("R8 irq cpu2 only", 32'(irq_o), 32'h4);
    evt(0, "R8 cpu0 sees none");
    rd(A_MCLR, 0, d);
    evt(2, "R8 cpu2 sees line10");
    wr(A_MCLR, 32'h400); wr(A_TGT + 16'd40, 32'h0);
    chk("R8 zero target", 32'(irq_o), 32'h0);
    // R10 simultaneous event read and clear of reported line
    hw_irq = '0; hw_irq[12] = 1'b1;
    wr(A_MCLR, 32'h1000);
    rd_en = 1'b1; rd_addr = A_EVT; rd_cpu = 2'd0;
    wr_en = 1'b1; wr_addr = A_MCLR; wr_data = 32'h1000;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 event word", rd_data, {16'd1, 16'd12});
    mask_m[12] = 1'b1;
    rd(A_MSET, 0, d); chk("R10 auto-mask wins", d[12], 1'b1);
    chk_irq("R10 irq after");
    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 6);
      int w  = $urandom_range(0, 1);
      case (op)
        0: hw_irq = {$urandom, $urandom} & {$urandom, $urandom};
        1: wr(A_MCLR + 16'(4*w), $urandom & $urandom);
        2: wr(A_MSET + 16'(4*w), $urandom & $urandom & $urandom);
        3: wr(w ? A_SSET : A_SCLR, $urandom & $urandom);
        4: wr(A_TGT + 16'(4*$urandom_range(0, N-1)), 32'($urandom_range(0, 15)));
        default: evt($urandom_range(0, C-1), "R4 random event");
      endcase
      @(negedge clk);
      chk_irq("R2 random irq");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule